// File: doc/BRIEF.md
# Standard-Definition Sync Timing Decoder

This block recovers line, field and frame timing from a standard-definition video input. A static two-bit selector picks one of four timing conventions. In the embedded-code convention, the block watches a 10-bit 4:2:2 pixel stream for timing reference words. In the other three conventions, it reads discrete active-low horizontal sync, vertical sync or field, and blank inputs. All inputs are sampled on the pixel clock. Edges are found by comparing each input against its value on the previous clock.

Every convention produces the same four outputs: a one-cycle start-of-line pulse, an odd/even field flag, a one-cycle start-of-frame pulse and an active-video flag. When the discrete blank input is switched off, the block counts lines from each field start and holds the active flag low over the vertical blanking lines of the chosen line standard. A static master select drives the recovered H, V and F timing bits onto three output pins. With master off, those pins stay low.

Top module: `sync_timing_decoder`

## Requirements
- R1: After a synchronous reset, every output is 0 when master output is disabled.
- R2: In embedded mode (mode 0), a word that follows 3FF, 000, 000 on three consecutive clocks is a timing word with bit 8 = F, bit 7 = V, bit 6 = H. A valid word with H=1 pulses the start-of-line output and clears active. A valid word with H=0 sets active to NOT V. The field flag takes F, and start-of-frame pulses when F changes from 1 to 0. All outputs change on the clock edge that samples the timing word.
- R3: Timing word bits 5..2 must equal {V^H, F^H, F^V, F^V^H}. If they do not, the error output pulses for one cycle and all timing state (field, active, H, V, F) is kept.
- R4: With master enabled in mode 0, the horizontal pin carries H, the blank pin carries V and the vertical pin carries F. With master disabled, all three pins are 0.
- R5: In mode 1, a change on the field input while horizontal sync is low starts a new field. The field flag takes the new field-input level (0 = odd), and start-of-frame pulses when that level is 0. A field-input change while horizontal sync is high is ignored.
- R6: In mode 3, the same rule applies with the qualifying horizontal sync level high. A field-input change while horizontal sync is low is ignored.
- R7: In mode 2, horizontal and vertical sync falling on the same clock starts an odd field and pulses start-of-frame. Vertical sync falling while horizontal sync is high starts an even field (field flag 1). Vertical sync falling while horizontal sync is already low is ignored.
- R8: In modes 1 to 3, a falling edge of horizontal sync gives a one-cycle start-of-line pulse on the clock edge that first samples it low.
- R9: In modes 1 to 3, with the blank input enabled, the active flag equals the blank input level sampled on the previous edge.
- R10: In modes 1 to 3, with the blank input disabled, the active flag is 0 until N start-of-line pulses have followed the field start. N is 20 for the 525-line standard (standard select 0) and 22 for 625-line (select 1).
- R11: In mode 0, a timing word not preceded by the full 3FF, 000, 000 pattern has no effect on field, start-of-line or start-of-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Timing convention (0 embedded, 1 field/H-low, 2 H/V, 3 field/H-high) |
| master_en | input | 1 | Drive recovered H, V, F onto output pins |
| pal_sel | input | 1 | Line standard for blanking count: 0 = 525, 1 = 625 |
| blank_use | input | 1 | Use discrete blank input for active flag |
| pix_in | input | 10 | Pixel stream with embedded timing words |
| hsync_n | input | 1 | Horizontal sync, active low |
| vsync_n | input | 1 | Vertical sync, or field input in modes 1 and 3 |
| blank_n | input | 1 | Blank input, low during blanking |
| sol_o | output | 1 | Start-of-line pulse |
| sof_o | output | 1 | Start-of-frame pulse |
| field_o | output | 1 | Field flag, 0 odd, 1 even |
| active_o | output | 1 | Active video flag |
| code_err_o | output | 1 | Protection-bit error pulse |
| hs_out | output | 1 | Recovered H in master mode |
| vs_out | output | 1 | Recovered F in master mode |
| blk_out | output | 1 | Recovered V / blanking in master mode |

## Verification
The assertions assume that the mode, master, standard and blank-enable selects change only while reset is held. They also assume that sync inputs are high during reset, so no edge is seen at the first sampled clock. The bench changes the selects only under reset, with all sync inputs released high. It drives inputs on the falling clock edge. It leaves at least one idle word between timing-reference patterns so that no two valid end-of-line words fall on adjacent clocks.

// File: rtl/sync_dec_pkg.sv
// Shared types for the sync timing decoder.
package sync_dec_pkg;
    typedef enum logic [1:0] {
        MODE_EMBED = 2'd0,
        MODE_FLD_LO = 2'd1,
        MODE_HV = 2'd2,
        MODE_FLD_HI = 2'd3
    } tmode_e;
endpackage

// File: rtl/embed_code_parser.sv
// Finds preamble + timing word in the pixel stream and decodes F/V/H.
// Assumes: preamble is all-ones, zero, zero; protection bits sit below H.
module embed_code_parser #(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] pix,
    output logic          sol,
    output logic          sof,
    output logic          err,
    output logic          active,
    output logic          f_bit,
    output logic          v_bit,
    output logic          h_bit
);
    localparam int FPOS = DW - 2;
    localparam int VPOS = DW - 3;
    localparam int HPOS = DW - 4;
    localparam int PTOP = DW - 5;
    localparam int PBOT = DW - 8;

    logic [DW-1:0] hist [3];
    logic          pre_ok, xf, xv, xh, prot_ok;

    // Decode the candidate timing word against the three-word history.
    always_comb begin
        pre_ok  = (hist[2] == {DW{1'b1}}) && (hist[1] == '0) && (hist[0] == '0);
        xf      = pix[FPOS];
        xv      = pix[VPOS];
        xh      = pix[HPOS];
        prot_ok = (pix[PTOP:PBOT] == {xv ^ xh, xf ^ xh, xf ^ xv, xf ^ xv ^ xh});
    end

    // Shift history and update timing state on valid words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) hist[i] <= '0;
            sol <= 1'b0; sof <= 1'b0; err <= 1'b0; active <= 1'b0;
            f_bit <= 1'b0; v_bit <= 1'b0; h_bit <= 1'b0;
        end else begin
            hist[2] <= hist[1];
            hist[1] <= hist[0];
            hist[0] <= pix;
            sol <= 1'b0;
            sof <= 1'b0;
            err <= 1'b0;
            if (pre_ok) begin
                if (!prot_ok) begin
                    err <= 1'b1;
                end else begin
                    f_bit <= xf;
                    v_bit <= xv;
                    h_bit <= xh;
                    if (xh) begin
                        sol    <= 1'b1;
                        active <= 1'b0;
                    end else begin
                        active <= ~xv;
                    end
                    if (f_bit && !xf) sof <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/discrete_sync_decoder.sv
// Edge detection and field qualification for discrete sync inputs.
// Assumes: inputs active low, high during reset, mode static.
module discrete_sync_decoder
    import sync_dec_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  tmode_e mode,
    input  logic   hs_n,
    input  logic   vs_n,
    input  logic   bl_n,
    output logic   sol,
    output logic   fstart,
    output logic   sof,
    output logic   field,
    output logic   h_act,
    output logic   bl_q
);
    logic hs_q, vs_q;
    logic hs_fall, vs_fall, fld_chg;
    logic new_fld, new_lvl;

    // Qualify field events for the selected convention.
    always_comb begin
        hs_fall = hs_q & ~hs_n;
        vs_fall = vs_q & ~vs_n;
        fld_chg = vs_q ^ vs_n;
        new_fld = 1'b0;
        new_lvl = 1'b0;
        unique case (mode)
            MODE_FLD_LO: begin new_fld = fld_chg & ~hs_n; new_lvl = vs_n; end
            MODE_FLD_HI: begin new_fld = fld_chg &  hs_n; new_lvl = vs_n; end
            MODE_HV: begin
                if (hs_fall && vs_fall) begin new_fld = 1'b1; new_lvl = 1'b0; end
                else if (vs_fall && hs_n) begin new_fld = 1'b1; new_lvl = 1'b1; end
            end
            default: begin new_fld = 1'b0; new_lvl = 1'b0; end
        endcase
    end

    // Register previous inputs and timing events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q <= 1'b1; vs_q <= 1'b1; bl_q <= 1'b0;
            sol <= 1'b0; fstart <= 1'b0; sof <= 1'b0; field <= 1'b0; h_act <= 1'b0;
        end else begin
            hs_q   <= hs_n;
            vs_q   <= vs_n;
            bl_q   <= bl_n;
            h_act  <= ~hs_n;
            sol    <= hs_fall;
            fstart <= new_fld;
            sof    <= new_fld & ~new_lvl;
            if (new_fld) field <= new_lvl;
        end
    end
endmodule

// File: rtl/line_blank_counter.sv
// Counts lines since field start and flags vertical blanking lines.
// Assumes: field start and line pulses are single-cycle.
module line_blank_counter #(
    parameter int LINE_W  = 10,
    parameter int VBL_525 = 20,
    parameter int VBL_625 = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pal,
    input  logic sol,
    input  logic fstart,
    output logic active
);
    localparam logic [LINE_W-1:0] N_A  = LINE_W'(VBL_525);
    localparam logic [LINE_W-1:0] N_B  = LINE_W'(VBL_625);
    localparam logic [LINE_W-1:0] LMAX = {LINE_W{1'b1}};

    logic [LINE_W-1:0] cnt;

    // Restart at field start, otherwise count lines with saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (fstart)              cnt <= '0;
        else if (sol && cnt != LMAX)  cnt <= cnt + 1'b1;
    end

    // Active once past the blanking lines of the chosen standard.
    always_comb active = (cnt >= (pal ? N_B : N_A));
endmodule

// File: rtl/sync_timing_decoder.sv
// Top: selects embedded or discrete timing source and master pin outputs.
// Assumes: mode/master/standard/blank selects static outside reset.
module sync_timing_decoder
    import sync_dec_pkg::*;
#(
    parameter int DW      = 10,
    parameter int LINE_W  = 10,
    parameter int VBL_525 = 20,
    parameter int VBL_625 = 22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_sel,
    input  logic          master_en,
    input  logic          pal_sel,
    input  logic          blank_use,
    input  logic [DW-1:0] pix_in,
    input  logic          hsync_n,
    input  logic          vsync_n,
    input  logic          blank_n,
    output logic          sol_o,
    output logic          sof_o,
    output logic          field_o,
    output logic          active_o,
    output logic          code_err_o,
    output logic          hs_out,
    output logic          vs_out,
    output logic          blk_out
);
    tmode_e mode;
    logic e_sol, e_sof, e_err, e_act, e_f, e_v, e_h;
    logic d_sol, d_fs, d_sof, d_fld, d_h, d_bl, lb_act, d_act;

    always_comb mode = tmode_e'(mode_sel);

    embed_code_parser #(.DW(DW)) u_embed (
        .clk(clk), .rst_n(rst_n), .pix(pix_in),
        .sol(e_sol), .sof(e_sof), .err(e_err), .active(e_act),
        .f_bit(e_f), .v_bit(e_v), .h_bit(e_h)
    );

    discrete_sync_decoder u_disc (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .hs_n(hsync_n), .vs_n(vsync_n), .bl_n(blank_n),
        .sol(d_sol), .fstart(d_fs), .sof(d_sof), .field(d_fld),
        .h_act(d_h), .bl_q(d_bl)
    );

    line_blank_counter #(.LINE_W(LINE_W), .VBL_525(VBL_525), .VBL_625(VBL_625)) u_lines (
        .clk(clk), .rst_n(rst_n), .pal(pal_sel),
        .sol(d_sol), .fstart(d_fs), .active(lb_act)
    );

    // Route the selected source to the outputs.
    always_comb begin
        d_act = blank_use ? d_bl : lb_act;
        if (mode == MODE_EMBED) begin
            sol_o = e_sol; sof_o = e_sof; field_o = e_f;
            active_o = e_act; code_err_o = e_err;
            hs_out = master_en & e_h;
            vs_out = master_en & e_f;
            blk_out = master_en & e_v;
        end else begin
            sol_o = d_sol; sof_o = d_sof; field_o = d_fld;
            active_o = d_act; code_err_o = 1'b0;
            hs_out = master_en & d_h;
            vs_out = master_en & d_fld;
            blk_out = master_en & ~d_act;
        end
    end
endmodule

// File: rtl/sync_timing_decoder_chk.sv
// Property checker bound to the sync timing decoder.
module sync_timing_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_sel,
    input logic       master_en,
    input logic       pal_sel,
    input logic       blank_use,
    input logic [9:0] pix_in,
    input logic       hsync_n,
    input logic       vsync_n,
    input logic       blank_n,
    input logic       sol_o,
    input logic       sof_o,
    input logic       field_o,
    input logic       active_o,
    input logic       code_err_o,
    input logic       hs_out,
    input logic       vs_out,
    input logic       blk_out
);
    // R3
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_err_o |-> (!sol_o && !sof_o));
    // R2
    sof_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_o |-> !field_o);
    // R4
    master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |-> (!hs_out && !vs_out && !blk_out));
    // R4
    master_eav_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd0 && master_en && sol_o) |-> hs_out);
    // R4
    master_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd0 && master_en && active_o) |-> (!hs_out && !blk_out));
    // R8
    sol_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sol_o |=> !sol_o);
    // R7
    hv_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd2 && sof_o && $past(rst_n)) |-> (!$past(hsync_n) && !$past(vsync_n)));
    // R9
    blank_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel != 2'd0 && blank_use && $past(rst_n)) |-> (active_o == $past(blank_n)));
endmodule

bind sync_timing_decoder sync_timing_decoder_chk u_chk (.*);

// File: tb/sync_timing_decoder_test.sv
module sync_timing_decoder_test;
    localparam int CLK_PER = 10;
    localparam int NVEC = 10;
    // {f,v,h,bad, sol,sof,err,act, hs,vs,blk}
    localparam logic [10:0] VEC [NVEC] = '{
        11'b0000_0001_000,
        11'b0010_1000_100,
        11'b0110_1000_101,
        11'b1100_0000_011,
        11'b1000_0001_010,
        11'b0111_0011_010,
        11'b1010_1000_110,
        11'b0110_1100_101,
        11'b0000_0001_000,
        11'b1001_0011_000
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic master_en = 1'b0, pal_sel = 1'b0, blank_use = 1'b0;
    logic [9:0] pix_in = 10'h200;
    logic hsync_n = 1'b1, vsync_n = 1'b1, blank_n = 1'b1;
    logic sol_o, sof_o, field_o, active_o, code_err_o, hs_out, vs_out, blk_out;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    sync_timing_decoder uut (.*);

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", rq, act, exp);
        end
    endtask

    task automatic restart(input logic [1:0] m, input logic mst, input logic pal, input logic bu);
        rst_n = 1'b0; hsync_n = 1'b1; vsync_n = 1'b1; blank_n = 1'b1; pix_in = 10'h200;
        mode_sel = m; master_en = mst; pal_sel = pal; blank_use = bu;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    function automatic logic [9:0] mk_xy(input logic f, input logic v, input logic h, input logic bad);
        logic [9:0] w;
        w = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
        if (bad) w[2] = ~w[2];
        return w;
    endfunction

    task automatic send_code(input logic [9:0] a, input logic [9:0] b, input logic [9:0] c, input logic [9:0] xy);
        pix_in = a; tick(1);
        pix_in = b; tick(1);
        pix_in = c; tick(1);
        pix_in = xy; tick(1);
    endtask

    task automatic hs_pulse();
        hsync_n = 1'b0; tick(2);
        hsync_n = 1'b1; tick(6);
    endtask

    function automatic logic [15:0] obs();
        return {9'd0, sol_o, sof_o, code_err_o, active_o, hs_out, vs_out, blk_out};
    endfunction

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        tick(1);
        // R1 reset state
        restart(2'd0, 1'b0, 1'b0, 1'b0);
        chk("R1 reset outputs", {8'd0, sol_o, sof_o, field_o, active_o, code_err_o, hs_out, vs_out, blk_out}, 16'd0);

        // R2 R3 R4 table walk, embedded mode with master
        restart(2'd0, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < NVEC; i++) begin
            send_code(10'h3FF, 10'h000, 10'h000, mk_xy(VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7]));
            chk($sformatf("R2 R3 R4 vector %0d", i), obs(), {9'd0, VEC[i][6:0]});
            pix_in = 10'h200; tick(1);
        end

        // R4 master off: pins stay low, field still follows F
        restart(2'd0, 1'b0, 1'b0, 1'b0);
        send_code(10'h3FF, 10'h000, 10'h000, mk_xy(1'b1, 1'b1, 1'b1, 1'b0));
        chk("R4 pins low master off", {13'd0, hs_out, vs_out, blk_out}, 16'd0);
        chk("R4 field without master", {15'd0, field_o}, 16'd1);

        // R11 broken preamble ignored
        restart(2'd0, 1'b1, 1'b0, 1'b0);
        send_code(10'h3FF, 10'h000, 10'h111, mk_xy(1'b1, 1'b0, 1'b1, 1'b0));
        chk("R11 broken preamble", {14'd0, field_o, sol_o}, 16'd0);

        // R5 R8 mode 1
        restart(2'd1, 1'b0, 1'b1, 1'b0);
        hsync_n = 1'b0; tick(1);
        chk("R8 sol on hsync fall", {15'd0, sol_o}, 16'd1);
        vsync_n = 1'b0; tick(1);
        chk("R5 qualified change odd", {14'd0, sof_o, field_o}, 16'b10);
        hsync_n = 1'b1; tick(2);
        vsync_n = 1'b1; tick(2);
        chk("R5 change with hsync high ignored", {15'd0, field_o}, 16'd0);
        hsync_n = 1'b0; tick(1);
        vsync_n = 1'b0; tick(1);
        chk("R5 odd again sof", {14'd0, sof_o, field_o}, 16'b10);
        vsync_n = 1'b1; tick(1);
        chk("R5 even field", {14'd0, sof_o, field_o}, 16'b01);
        hsync_n = 1'b1; tick(4);
        // R10 625-line blanking count
        for (int i = 0; i < 21; i++) hs_pulse();
        chk("R10 625 still blanked", {15'd0, active_o}, 16'd0);
        hs_pulse();
        chk("R10 625 active", {15'd0, active_o}, 16'd1);

        // R6 mode 3
        restart(2'd3, 1'b0, 1'b0, 1'b0);
        vsync_n = 1'b0; tick(2);
        vsync_n = 1'b1; tick(1);
        chk("R6 even on change with hsync high", {14'd0, sof_o, field_o}, 16'b01);
        hsync_n = 1'b0; tick(1);
        vsync_n = 1'b0; tick(2);
        chk("R6 change with hsync low ignored", {15'd0, field_o}, 16'd1);
        hsync_n = 1'b1; tick(1);
        vsync_n = 1'b1; tick(2);
        vsync_n = 1'b0; tick(1);
        chk("R6 odd start sof", {14'd0, sof_o, field_o}, 16'b10);

        // R7 mode 2
        restart(2'd2, 1'b0, 1'b0, 1'b0);
        hsync_n = 1'b0; vsync_n = 1'b0; tick(1);
        chk("R7 coincident odd", {13'd0, sol_o, sof_o, field_o}, 16'b110);
        tick(1); hsync_n = 1'b1; vsync_n = 1'b1; tick(2);
        vsync_n = 1'b0; tick(1);
        chk("R7 even with hsync high", {14'd0, sof_o, field_o}, 16'b01);
        vsync_n = 1'b1; tick(2);
        hsync_n = 1'b0; tick(2);
        vsync_n = 1'b0; tick(2);
        chk("R7 vsync fall with hsync low ignored", {15'd0, field_o}, 16'd1);
        hsync_n = 1'b1; vsync_n = 1'b1; tick(2);
        hsync_n = 1'b0; vsync_n = 1'b0; tick(1);
        chk("R7 odd again", {14'd0, sof_o, field_o}, 16'b10);
        tick(1); hsync_n = 1'b1; vsync_n = 1'b1; tick(4);
        // R10 525-line blanking count
        for (int i = 0; i < 19; i++) hs_pulse();
        chk("R10 525 still blanked", {15'd0, active_o}, 16'd0);
        hs_pulse();
        chk("R10 525 active", {15'd0, active_o}, 16'd1);

        // R9 blank input used
        restart(2'd2, 1'b0, 1'b0, 1'b1);
        blank_n = 1'b1; tick(1);
        chk("R9 blank high active", {15'd0, active_o}, 16'd1);
        blank_n = 1'b0; tick(1);
        chk("R9 blank low inactive", {15'd0, active_o}, 16'd0);

        done = 1'b1;
        finish_run();
    end
endmodule